// File: doc/BRIEF.md
# SDRAM Mode-Register Command Issuer

This block holds one 15-bit mode word for each SDRAM chip-select space and turns every software write to that word into a mode-programming command on the SDRAM pins, with no further action from software. A CPU writes a 32-bit word at the address of a space. The low 15 bits are kept and can be read back. The same write starts a short sequence: one command cycle with chip select, RAS#, CAS# and WE# all low, then a fixed settle wait (tMRD). The mode word is placed two address positions up, on address pins A16 to A2. The bank-address pins sent with the command come from a side input that is sampled with the write. Bank value 00 gives a normal mode register set, and 10 gives an extended mode register set.

A per-space busy flag stays high while the sequence runs. A write is refused while any sequence is in progress, and also while the target space reports self-refresh, power-down or deep power-down. A refused write changes nothing. A checker output per space flags a programmed mode word that the controller cannot work with: a burst length other than 1, or a CAS latency that differs from the configured one.

Top module: `sdram_modecmd_top`

## Requirements
- R1: After reset both mode words read as 0, both busy flags and both warn flags are 0, and the pins are idle: all chip selects, RAS#, CAS# and WE# high, with address and bank pins at 0.
- R2: A register read at byte offset 4*m returns bits 14..0 of space m's mode word and 0 in bits 31..15. Reads at any other offset return 0. Writes at any other offset change no register and issue no command.
- R3: An accepted write issues exactly one command cycle, in the cycle right after the write's clock edge. In that cycle chip select m is low, the other chip selects are high, and RAS#, CAS# and WE# are low. In every other cycle these pins are high.
- R4: During the command cycle, address pins A16..A2 carry mode bits 14..0, and A1, A0 and every pin above A16 are 0.
- R5: During the command cycle the two bank pins equal the bank-select input sampled with the write (00 = mode register set, 10 = extended mode register set).
- R6: busy[m] is high from the command cycle through the TMRD cycles that follow it (1+TMRD cycles in total) and is low otherwise. At most one busy bit is high at any time.
- R7: A write is refused while any busy bit is high, including the last wait cycle, or while the target space's self-refresh, power-down or deep-power-down input is high. A refused write leaves both mode words unchanged and issues no command.
- R8: On each accepted write with bank select 00, warn[m] is set if mode bits 2..0 (burst length) are not 000, or if mode bits 6..4 (CAS latency) differ from the configured latency input, and is cleared otherwise. An accepted write with any other bank select clears warn[m].
- R9: A write to one space never changes the other space's mode word or warn flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_addr | input | 4 | Byte offset of the register (space m at 4*m) |
| cpu_wdata | input | 32 | Write data; bits 14..0 are the mode word |
| wr_bank_sel | input | 2 | Bank pins to send with the command, sampled with the write |
| cpu_rdata | output | 32 | Read data for cpu_addr (combinational) |
| cfg_cas_lat | input | 3 | Configured CAS latency that the mode word is compared against |
| lp_sref | input | 2 | Per-space self-refresh active |
| lp_pdown | input | 2 | Per-space power-down active |
| lp_dpd | input | 2 | Per-space deep power-down active |
| mrs_busy | output | 2 | Per-space command sequence in progress |
| mode_warn | output | 2 | Per-space unsupported mode word flag |
| sd_cs_n | output | 2 | Chip selects, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 19 | SDRAM address pins A18..A0 |
| sd_ba | output | 2 | SDRAM bank address pins |

## Verification
The hardest case to reach from the ports is a second write that arrives while a sequence is still settling, and in particular one that lands on the very last wait cycle, where an off-by-one in the wait counter would let it through. A directed case writes one space and then presents a write to the other space on every following cycle up to and including that last busy cycle. It then checks that no second chip select ever went low and that the other space's word did not change. Random writes with a fixed seed cover mixed bank selects, low-power refusals and legal and illegal burst-length and latency fields. They run alongside this directed case.

// File: rtl/sdmr_pkg.sv
// Package: shared constants and types for the SDRAM mode-register command issuer.
// Assumes a 15-bit mode word and a two-bit bank address on the device.
package sdmr_pkg;
    localparam int MODE_W   = 15;
    localparam int BA_W     = 2;
    localparam int BL_LSB   = 0;   // burst-length field position in the mode word
    localparam int CL_LSB   = 4;   // CAS-latency field position in the mode word
    localparam int FIELD_W  = 3;
    localparam logic [BA_W-1:0] BA_MRS  = 2'b00;
    localparam logic [BA_W-1:0] BA_EMRS = 2'b10;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_CMD  = 2'd1,
        SEQ_WAIT = 2'd2
    } seq_state_e;
endpackage

// File: rtl/sdmr_rule_check.sv
// Module: combinational legality check of a mode word before it is stored.
// Only a standard mode register set (bank 00) is judged; extended words
// never raise the flag. Burst length must encode 1 (000), and the CAS-latency
// field must match the latency the controller is configured for.
module sdmr_rule_check
    import sdmr_pkg::*;
(
    input  logic [MODE_W-1:0]  mode_word,
    input  logic [BA_W-1:0]    bank_sel,
    input  logic [FIELD_W-1:0] cfg_cl,
    output logic               bad_word
);
    logic [FIELD_W-1:0] bl_field;
    logic [FIELD_W-1:0] cl_field;

    // Extract the two judged fields and compare them against the rules.
    always_comb begin
        bl_field = mode_word[BL_LSB +: FIELD_W];
        cl_field = mode_word[CL_LSB +: FIELD_W];
        bad_word = (bank_sel == BA_MRS) &&
                   ((bl_field != '0) || (cl_field != cfg_cl));
    end
endmodule

// File: rtl/sdmr_space_reg.sv
// Module: storage for one chip-select space: the mode word and its warn flag.
// Assumes the top has already qualified the write (decode, busy, low-power),
// so wr_take is a fully accepted write for this space.
module sdmr_space_reg
    import sdmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_take,
    input  logic [MODE_W-1:0]  wr_mode,
    input  logic [BA_W-1:0]    wr_ba,
    input  logic [FIELD_W-1:0] cfg_cl,
    output logic [MODE_W-1:0]  mode_q,
    output logic               warn_q
);
    logic bad_word;

    sdmr_rule_check u_rule (
        .mode_word (wr_mode),
        .bank_sel  (wr_ba),
        .cfg_cl    (cfg_cl),
        .bad_word  (bad_word)
    );

    // Store the mode word and the verdict on every accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            warn_q <= 1'b0;
        end else if (wr_take) begin
            mode_q <= wr_mode;
            warn_q <= bad_word;
        end
    end

    // R7/R9: without an accepted write the stored word must not move.
    a_r7_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_take |=> $stable(mode_q));
    // R8: the warn flag only changes on an accepted write.
    a_r8_warn_held: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_take |=> $stable(warn_q));
endmodule

// File: rtl/sdmr_cmd_seq.sv
// Module: shared command sequencer that drives the SDRAM command pins.
// One sequence at a time: a command cycle, then TMRD wait cycles. The pins
// are registered, so the command appears in the cycle after the start edge.
// Assumes start is only raised while busy is low.
module sdmr_cmd_seq
    import sdmr_pkg::*;
#(
    parameter int NUM_SP    = 2,
    parameter int SD_ADDR_W = 19,
    parameter int TMRD      = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [NUM_SP-1:0]      start_sel,
    input  logic [MODE_W-1:0]      start_mode,
    input  logic [BA_W-1:0]        start_ba,
    output logic                   busy,
    output logic [NUM_SP-1:0]      busy_sp,
    output logic [NUM_SP-1:0]      cs_n,
    output logic                   ras_n,
    output logic                   cas_n,
    output logic                   we_n,
    output logic [SD_ADDR_W-1:0]   addr,
    output logic [BA_W-1:0]        ba
);
    localparam int CNT_W = (TMRD < 2) ? 1 : $clog2(TMRD);

    seq_state_e          state;
    logic [NUM_SP-1:0]   sel_q;
    logic [CNT_W-1:0]    wait_cnt;

    // Advance the command sequence and hold the owning space.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            sel_q    <= '0;
            wait_cnt <= '0;
        end else begin
            case (state)
                SEQ_IDLE: if (start) begin
                    state <= SEQ_CMD;
                    sel_q <= start_sel;
                end
                SEQ_CMD: begin
                    if (TMRD == 0) begin
                        state <= SEQ_IDLE;
                    end else begin
                        state    <= SEQ_WAIT;
                        wait_cnt <= CNT_W'(TMRD - 1);
                    end
                end
                SEQ_WAIT: begin
                    if (wait_cnt == '0) state <= SEQ_IDLE;
                    else                wait_cnt <= wait_cnt - 1'b1;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Register the pins: the command for one cycle after start, idle otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !(start && state == SEQ_IDLE)) begin
            cs_n  <= '1;
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            we_n  <= 1'b1;
            addr  <= '0;
            ba    <= '0;
        end else begin
            cs_n  <= ~start_sel;
            ras_n <= 1'b0;
            cas_n <= 1'b0;
            we_n  <= 1'b0;
            addr  <= SD_ADDR_W'({start_mode, 2'b00});
            ba    <= start_ba;
        end
    end

    // Report which space owns the running sequence.
    always_comb begin
        busy    = (state != SEQ_IDLE);
        busy_sp = busy ? sel_q : '0;
    end

    // R3: a command lasts exactly one cycle.
    a_r3_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |=> ras_n);
    // R3: at most one chip select is active.
    a_r3_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    // R4: the two lowest address pins stay low during a command.
    a_r4_low_pins_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (addr[1:0] == 2'b00));
    // R6: a command is always covered by a busy flag of the same space.
    a_r6_cmd_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (busy_sp == ~cs_n));
    // R6: at most one busy bit.
    a_r6_busy_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy_sp));
endmodule

// File: rtl/sdram_modecmd_top.sv
// Module: top of the SDRAM mode-register command issuer.
// Decodes the CPU port, qualifies writes against busy and low-power status,
// keeps one mode register per space and hands accepted writes to the shared
// sequencer. Assumes one CPU write per cycle at most.
module sdram_modecmd_top
    import sdmr_pkg::*;
#(
    parameter int NUM_SP    = 2,
    parameter int CPU_AW    = 4,
    parameter int SD_ADDR_W = 19,
    parameter int TMRD      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_wr,
    input  logic [CPU_AW-1:0]     cpu_addr,
    input  logic [31:0]           cpu_wdata,
    input  logic [BA_W-1:0]       wr_bank_sel,
    output logic [31:0]           cpu_rdata,
    input  logic [FIELD_W-1:0]    cfg_cas_lat,
    input  logic [NUM_SP-1:0]     lp_sref,
    input  logic [NUM_SP-1:0]     lp_pdown,
    input  logic [NUM_SP-1:0]     lp_dpd,
    output logic [NUM_SP-1:0]     mrs_busy,
    output logic [NUM_SP-1:0]     mode_warn,
    output logic [NUM_SP-1:0]     sd_cs_n,
    output logic                  sd_ras_n,
    output logic                  sd_cas_n,
    output logic                  sd_we_n,
    output logic [SD_ADDR_W-1:0]  sd_addr,
    output logic [BA_W-1:0]       sd_ba
);
    localparam int PAD_W = 32 - MODE_W;

    logic [NUM_SP-1:0]  hit;
    logic [NUM_SP-1:0]  take;
    logic [MODE_W-1:0]  mode_q [NUM_SP];
    logic               seq_busy;
    logic [MODE_W-1:0]  wr_mode;

    assign wr_mode = cpu_wdata[MODE_W-1:0];

    for (genvar m = 0; m < NUM_SP; m++) begin : g_space
        // Decode this space's offset and qualify the write.
        always_comb begin
            hit[m]  = (cpu_addr == CPU_AW'(4 * m));
            take[m] = cpu_wr && hit[m] && !seq_busy &&
                      !(lp_sref[m] || lp_pdown[m] || lp_dpd[m]);
        end

        sdmr_space_reg u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_take (take[m]),
            .wr_mode (wr_mode),
            .wr_ba   (wr_bank_sel),
            .cfg_cl  (cfg_cas_lat),
            .mode_q  (mode_q[m]),
            .warn_q  (mode_warn[m])
        );
    end

    // Return the addressed mode word, zero-padded; unmapped offsets read 0.
    always_comb begin
        cpu_rdata = '0;
        for (int m = 0; m < NUM_SP; m++) begin
            if (hit[m]) cpu_rdata = {{PAD_W{1'b0}}, mode_q[m]};
        end
    end

    sdmr_cmd_seq #(
        .NUM_SP    (NUM_SP),
        .SD_ADDR_W (SD_ADDR_W),
        .TMRD      (TMRD)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (|take),
        .start_sel  (take),
        .start_mode (wr_mode),
        .start_ba   (wr_bank_sel),
        .busy       (seq_busy),
        .busy_sp    (mrs_busy),
        .cs_n       (sd_cs_n),
        .ras_n      (sd_ras_n),
        .cas_n      (sd_cas_n),
        .we_n       (sd_we_n),
        .addr       (sd_addr),
        .ba         (sd_ba)
    );

    // R7: no write is taken while a sequence runs.
    a_r7_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_busy != '0) |-> (take == '0));
    // R7: a write while busy leaves the pins idle next cycle.
    a_r7_refused_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && mrs_busy != '0) |=> (sd_cs_n == '1));
    // R2: the upper read bits are always zero.
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata[31:MODE_W] == '0);
endmodule

// File: tb/sdram_modecmd_top_tb.sv
module sdram_modecmd_top_tb_top;
    localparam int TMRD = 2;
    localparam int AW   = 19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [3:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [1:0]  wr_bank_sel = '0;
    logic [31:0] cpu_rdata;
    logic [2:0]  cfg_cas_lat = 3'd2;
    logic [1:0]  lp_sref = '0, lp_pdown = '0, lp_dpd = '0;
    logic [1:0]  mrs_busy, mode_warn, sd_cs_n, sd_ba;
    logic        sd_ras_n, sd_cas_n, sd_we_n;
    logic [AW-1:0] sd_addr;

    int checks = 0;
    int failures = 0;
    logic [14:0] m_mode [2];
    logic        m_warn [2];

    always #2 clk = ~clk;

    sdram_modecmd_top #(.TMRD(TMRD)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .wr_bank_sel(wr_bank_sel), .cpu_rdata(cpu_rdata),
        .cfg_cas_lat(cfg_cas_lat), .lp_sref(lp_sref), .lp_pdown(lp_pdown),
        .lp_dpd(lp_dpd), .mrs_busy(mrs_busy), .mode_warn(mode_warn),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_warn(logic [14:0] d, logic [1:0] ba, logic [2:0] cl);
        return (ba == 2'b00) && ((d[2:0] != 3'b000) || (d[6:4] != cl));
    endfunction

    function automatic logic [AW-1:0] exp_addr(logic [14:0] d);
        return AW'({d, 2'b00});
    endfunction

    task automatic chk_idle(string req);
        chk(req, {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 5'b11111);
    endtask

    // Read both spaces and compare words and warn flags with the model.
    task automatic readback(string req);
        for (int s = 0; s < 2; s++) begin
            cpu_addr = 4'(4 * s);
            #1;
            chk(req, cpu_rdata, {17'b0, m_mode[s]});
            chk("R8", mode_warn[s], m_warn[s]);
        end
    endtask

    // One write from idle, followed through its whole sequence.
    task automatic issue(int sp, logic [31:0] d, logic [1:0] ba, logic [2:0] lp);
        logic acc;
        acc = (lp == 3'b000);
        @(negedge clk);
        cpu_addr = 4'(4 * sp); cpu_wdata = d; wr_bank_sel = ba; cpu_wr = 1'b1;
        lp_sref[sp] = lp[0]; lp_pdown[sp] = lp[1]; lp_dpd[sp] = lp[2];
        @(negedge clk);
        cpu_wr = 1'b0; lp_sref = '0; lp_pdown = '0; lp_dpd = '0;
        if (acc) begin
            chk("R3", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, {~(2'(1) << sp), 3'b000});
            chk("R4", sd_addr, exp_addr(d[14:0]));
            chk("R5", sd_ba, ba);
            chk("R6", mrs_busy, 2'(1) << sp);
            m_mode[sp] = d[14:0];
            m_warn[sp] = exp_warn(d[14:0], ba, cfg_cas_lat);
            for (int k = 0; k < TMRD; k++) begin
                @(negedge clk);
                chk("R6", mrs_busy, 2'(1) << sp);
                chk_idle("R3");
            end
            @(negedge clk);
        end else begin
            chk_idle("R7");
        end
        chk("R6", mrs_busy, 2'b00);
        readback(acc ? "R9" : "R7");
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=done", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        m_mode[0] = '0; m_mode[1] = '0; m_warn[0] = 1'b0; m_warn[1] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk_idle("R1");
        chk("R1", {sd_addr, sd_ba, mrs_busy, mode_warn}, '0);
        readback("R1");

        // Directed: legal MRS, EMRS, illegal burst length, latency mismatch.
        issue(0, 32'hFFFF_0020, 2'b00, 3'b000); // R2 upper ignored, legal word
        issue(1, 32'h0000_7FFF, 2'b10, 3'b000); // R5 EMRS, R4 all ones
        issue(0, 32'h0000_0021, 2'b00, 3'b000); // R8 burst length bad
        issue(1, 32'h0000_0030, 2'b00, 3'b000); // R8 latency mismatch
        issue(0, 32'h0000_4000, 2'b00, 3'b001); // R7 self-refresh
        issue(1, 32'h0000_1234, 2'b00, 3'b010); // R7 power-down
        issue(0, 32'h0000_0555, 2'b00, 3'b100); // R7 deep power-down

        // R2: unmapped offset writes nothing, reads zero.
        @(negedge clk);
        cpu_addr = 4'h8; cpu_wdata = 32'h1FFF; cpu_wr = 1'b1;
        #1 chk("R2", cpu_rdata, 32'h0);
        @(negedge clk);
        cpu_wr = 1'b0;
        chk_idle("R2");
        chk("R2", mrs_busy, 2'b00);
        readback("R2");

        // R7: writes to space 1 on every busy cycle, including the last one.
        @(negedge clk);
        cpu_addr = 4'h0; cpu_wdata = 32'h0020; wr_bank_sel = 2'b00; cpu_wr = 1'b1;
        for (int k = 0; k <= TMRD + 1; k++) begin
            @(negedge clk);
            if (k == 0) chk("R3", sd_cs_n, 2'b10);
            else        chk("R7", sd_cs_n[1], 1'b1);
            if (k <= TMRD) begin
                cpu_addr = 4'h4; cpu_wdata = 32'h0ABC; cpu_wr = 1'b1;
            end else begin
                cpu_wr = 1'b0;
                chk("R6", mrs_busy, 2'b00);
            end
        end
        m_mode[0] = 15'h0020; m_warn[0] = exp_warn(15'h0020, 2'b00, cfg_cas_lat);
        readback("R7");

        // Random mix.
        for (int i = 0; i < 200; i++) begin
            int sp;
            logic [31:0] d;
            logic [1:0] ba;
            logic [2:0] lp;
            sp = int'($urandom % 2);
            d = $urandom;
            ba = ($urandom % 2 == 0) ? 2'b00 : 2'b10;
            lp = ($urandom % 4 == 0) ? 3'(1 << ($urandom % 3)) : 3'b000;
            cfg_cas_lat = 3'($urandom);
            if ($urandom % 3 == 0) begin
                d[2:0] = 3'b000; d[6:4] = cfg_cas_lat;
            end
            issue(sp, d, ba, lp);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule